// File: doc/BRIEF.md
# Programmed I/O Flag Controller

This block carries out the I/O instruction group of a small accumulator machine. It serves two input channels and two output channels. When the CPU presents an instruction byte with an execute strobe, the block decodes the byte. It then picks a direction and a device, and carries out any mix of three functions on that device: test its ready flag, clear its ready flag, and move a byte between the accumulator and the device.

Each device owns one ready flag, and only the device side sets it. For an input channel, a set flag means a byte is waiting. For an output channel, it means the channel can take a byte. Software polls a flag with a skip instruction, which asks the CPU to step its program counter past the next word. Software clears a flag with a reset instruction. No interrupts are involved. A load to an output hands the accumulator value to the channel with a one-cycle write strobe, and the same load also clears that channel's flag.

Top module: `pio_flag_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four ready flags are clear. In the cycle after reset releases, `skip_req`, `ac_wr` and `out_wr` are low.
- R2: A one-cycle pulse on `in_set[d]` or `out_set[d]` sets that device's flag at the next clock edge. The flag stays set until an instruction clears it.
- R3: An instruction is an I/O instruction when bits [7:5] equal 3'b111. Bit 4 selects the direction (0 input, 1 output) and bit 3 selects the device. Bit 0 is the skip function. During `exec_stb`, `skip_req` is high in the same cycle exactly when the selected flag is set.
- R4: `skip_req` is low whenever `exec_stb` is low, and whenever the opcode is not 3'b111.
- R5: Bit 1 is the reset function. It clears only the selected flag, at the next edge.
- R6: If a device sets its flag in the same cycle that an instruction clears it, the flag ends up set.
- R7: Bit 2 with direction 0 is a read. In the strobe cycle, `ac_wr` is high and `ac_out` carries the selected input's byte. At all other times `ac_wr` is low and `ac_out` is zero.
- R8: Bit 2 with direction 1 is a load. In the next cycle, `out_data` for the selected device holds `ac_in` and `out_wr[dev]` is high for exactly that cycle. The load also clears that output's flag.
- R9: When skip is combined with reset or transfer, the skip tests the flag as it stood before the instruction.
- R10: A strobe with a non-I/O opcode changes no flag, writes nothing and requests no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_stb | input | 1 | Execute strobe for `instr`, one cycle per instruction |
| instr | input | 8 | Instruction byte |
| ac_in | input | DATA_W | Accumulator value from the CPU |
| ac_out | output | DATA_W | Byte read from the selected input (zero otherwise) |
| ac_wr | output | 1 | Accumulator write request for a read |
| skip_req | output | 1 | Request to increment the program counter |
| in_data | input | 2*DATA_W | Input channel bytes, device d at [d*DATA_W +: DATA_W] |
| in_set | input | 2 | Input ready pulses, one per device |
| out_data | output | 2*DATA_W | Output channel bytes, device d at [d*DATA_W +: DATA_W] |
| out_wr | output | 2 | One-cycle write strobes, one per output device |
| out_set | input | 2 | Output ready pulses, one per device |

## Verification
The assertions assume that `exec_stb` carries a stable instruction for one cycle. They also assume that device set pulses may arrive in any cycle, including the cycle of a clear on the same flag. The stimulus mixes directed sequences for each function with a long pseudo-random run. That run draws opcodes, function bits, set pulses and data freely, and it keeps every input steady between falling edges. So the set-versus-clear collisions and the combined functions both occur many times.

// File: rtl/pio_pkg.sv
// Package: shared encodings and the decoded command type for the
// programmed I/O flag controller. Assumes one opcode value marks I/O.
package pio_pkg;
    localparam logic [2:0] IO_OPCODE = 3'b111;
    localparam int         N_DEV     = 2;   // devices per direction
    localparam int         FN_SKIP   = 0;
    localparam int         FN_CLR    = 1;
    localparam int         FN_XFER   = 2;
    localparam int         DIR_BIT   = 4;
    localparam int         DEV_BIT   = 3;

    typedef struct packed {
        logic valid;   // strobed I/O instruction
        logic dir;     // 0 input, 1 output
        logic dev;     // device within direction
        logic skip;
        logic clr;
        logic xfer;
    } pio_cmd_t;
endpackage

// File: rtl/pio_decode.sv
// Module: decodes the instruction byte into a command record.
// Assumes instr is valid whenever exec_stb is high; purely combinational.
module pio_decode
    import pio_pkg::*;
(
    input  logic       exec_stb,
    input  logic [7:0] instr,
    output pio_cmd_t   cmd
);
    // Split opcode and function fields; gate validity with the strobe.
    always_comb begin
        cmd.valid = exec_stb && (instr[7:5] == IO_OPCODE);
        cmd.dir   = instr[DIR_BIT];
        cmd.dev   = instr[DEV_BIT];
        cmd.skip  = instr[FN_SKIP];
        cmd.clr   = instr[FN_CLR];
        cmd.xfer  = instr[FN_XFER];
    end
endmodule

// File: rtl/pio_flag_bank.sv
// Module: a bank of ready flags, one per device. Set requests from the
// device side win over clear requests from instructions in the same cycle.
module pio_flag_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar d = 0; d < N; d++) begin : g_flag
        // One flag: reset low, set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)         flag_o[d] <= 1'b0;
            else if (set_i[d])  flag_o[d] <= 1'b1;
            else if (clr_i[d])  flag_o[d] <= 1'b0;
        end
    end
endmodule

// File: rtl/pio_out_port.sv
// Module: output channel registers. On a load request it captures the
// accumulator for the addressed device and raises its strobe for one cycle.
module pio_out_port #(
    parameter int N      = 2,
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    load_i,
    input  logic [DATA_W-1:0] ac_i,
    output logic [N*DATA_W-1:0] data_o,
    output logic [N-1:0]    wr_o
);
    for (genvar d = 0; d < N; d++) begin : g_port
        // Data register for device d, held until the next load.
        always_ff @(posedge clk) begin
            if (!rst_n)          data_o[d*DATA_W +: DATA_W] <= '0;
            else if (load_i[d])  data_o[d*DATA_W +: DATA_W] <= ac_i;
        end
        // Strobe for device d, high for the cycle after the load.
        always_ff @(posedge clk) begin
            if (!rst_n) wr_o[d] <= 1'b0;
            else        wr_o[d] <= load_i[d];
        end
    end
endmodule

// File: rtl/pio_flag_ctrl.sv
// Module: top of the programmed I/O flag controller. It decodes I/O
// instructions, keeps per-device ready flags, answers skip tests and moves
// bytes between the accumulator and the channels. Assumes a one-cycle strobe.
module pio_flag_ctrl
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    exec_stb,
    input  logic [7:0]              instr,
    input  logic [DATA_W-1:0]       ac_in,
    output logic [DATA_W-1:0]       ac_out,
    output logic                    ac_wr,
    output logic                    skip_req,
    input  logic [2*DATA_W-1:0]     in_data,
    input  logic [1:0]              in_set,
    output logic [2*DATA_W-1:0]     out_data,
    output logic [1:0]              out_wr,
    input  logic [1:0]              out_set
);
    localparam int N = N_DEV;

    pio_cmd_t     cmd;
    logic [N-1:0] dev_hot;
    logic [N-1:0] in_clr, out_clr, out_load;
    logic [N-1:0] in_flag, out_flag;

    pio_decode u_dec (.exec_stb(exec_stb), .instr(instr), .cmd(cmd));

    // One-hot device select from the decoded device bit.
    always_comb begin
        for (int d = 0; d < N; d++) dev_hot[d] = (cmd.dev == d[0]);
    end

    // Per-device clear and load requests for each direction.
    always_comb begin
        for (int d = 0; d < N; d++) begin
            in_clr[d]   = cmd.valid && !cmd.dir && dev_hot[d] && cmd.clr;
            out_load[d] = cmd.valid &&  cmd.dir && dev_hot[d] && cmd.xfer;
            out_clr[d]  = cmd.valid &&  cmd.dir && dev_hot[d] && cmd.clr;
            out_clr[d]  = out_clr[d] || out_load[d];
        end
    end

    pio_flag_bank #(.N(N)) u_in_flags (
        .clk(clk), .rst_n(rst_n), .set_i(in_set), .clr_i(in_clr), .flag_o(in_flag)
    );
    pio_flag_bank #(.N(N)) u_out_flags (
        .clk(clk), .rst_n(rst_n), .set_i(out_set), .clr_i(out_clr), .flag_o(out_flag)
    );
    pio_out_port #(.N(N), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load_i(out_load), .ac_i(ac_in),
        .data_o(out_data), .wr_o(out_wr)
    );

    // Skip test on the registered flag, i.e. its value before this instruction.
    always_comb begin
        logic sel_flag;
        sel_flag = cmd.dir ? out_flag[cmd.dev] : in_flag[cmd.dev];
        skip_req = cmd.valid && cmd.skip && sel_flag;
    end

    // Read path: selected input byte onto the accumulator bus.
    always_comb begin
        ac_wr  = cmd.valid && !cmd.dir && cmd.xfer;
        ac_out = ac_wr ? in_data[cmd.dev*DATA_W +: DATA_W] : '0;
    end
endmodule

// File: rtl/pio_flag_ctrl_chk.sv
// Checker: properties of the flag controller, bound to every instance.
module pio_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exec_stb,
    input logic [7:0] instr,
    input logic       skip_req,
    input logic       ac_wr,
    input logic [1:0] out_wr,
    input logic [1:0] in_set,
    input logic [1:0] out_set,
    input logic [1:0] in_flag,
    input logic [1:0] out_flag
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (out_wr == 2'b00));
    assert_in_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_set[0] |=> in_flag[0]);
    assert_out_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_set[1] |=> out_flag[1]);
    assert_skip_in_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> (exec_stb && instr[7:5] == 3'b111));
    assert_read_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ac_wr |-> (exec_stb && !instr[4] && instr[2]));
    assert_wr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_wr));
    assert_wr_after_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr != 2'b00) |-> $past(exec_stb));
endmodule

bind pio_flag_ctrl pio_flag_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .instr(instr),
    .skip_req(skip_req), .ac_wr(ac_wr), .out_wr(out_wr),
    .in_set(in_set), .out_set(out_set), .in_flag(in_flag), .out_flag(out_flag)
);

// File: tb/pio_flag_ctrl_tb.sv
`timescale 1ns/1ps
module pio_flag_ctrl_tb_top;
    localparam int W = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exec_stb = 1'b0;
    logic [7:0] instr = '0;
    logic [W-1:0] ac_in = '0;
    logic [W-1:0] ac_out;
    logic ac_wr, skip_req;
    logic [2*W-1:0] in_data = '0;
    logic [1:0] in_set = '0;
    logic [2*W-1:0] out_data;
    logic [1:0] out_wr;
    logic [1:0] out_set = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model state
    bit m_in[2], m_out[2], m_wr[2];
    logic [W-1:0] m_data[2];

    always #2.5 clk = ~clk;

    pio_flag_ctrl #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .instr(instr),
        .ac_in(ac_in), .ac_out(ac_out), .ac_wr(ac_wr), .skip_req(skip_req),
        .in_data(in_data), .in_set(in_set), .out_data(out_data),
        .out_wr(out_wr), .out_set(out_set)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model for the current inputs.
    task automatic compare(input string tag);
        bit io, sf, exp_skip, exp_rd;
        io = exec_stb && instr[7:5] == 3'b111;
        sf = instr[4] ? m_out[instr[3]] : m_in[instr[3]];
        exp_skip = io && instr[0] && sf;
        exp_rd = io && !instr[4] && instr[2];
        chk({tag, " R3 skip"}, skip_req, exp_skip);
        chk({tag, " R7 ac_wr"}, ac_wr, exp_rd);
        chk({tag, " R7 ac_out"}, ac_out, exp_rd ? in_data[instr[3]*W +: W] : 0);
        chk({tag, " R8 out_wr"}, out_wr, {m_wr[1], m_wr[0]});
        chk({tag, " R8 out_data"}, out_data, {m_data[1], m_data[0]});
    endtask

    // Model update at a clock edge with the held inputs.
    task automatic model_edge();
        bit io;
        io = exec_stb && instr[7:5] == 3'b111;
        for (int d = 0; d < 2; d++) begin
            bit sel, ld, cl;
            sel = (instr[3] == d[0]);
            ld = io && instr[4] && sel && instr[2];
            m_wr[d] = ld;
            if (ld) m_data[d] = ac_in;
            cl = io && sel && instr[1];
            if (in_set[d]) m_in[d] = 1;
            else if (cl && !instr[4]) m_in[d] = 0;
            if (out_set[d]) m_out[d] = 1;
            else if ((cl || ld) && instr[4]) m_out[d] = 0;
        end
        if (!rst_n) begin
            m_in = '{0, 0}; m_out = '{0, 0}; m_wr = '{0, 0}; m_data = '{0, 0};
        end
    endtask

    task automatic step(input string tag, input bit stb, input logic [7:0] ins,
                        input logic [1:0] iset, input logic [1:0] oset);
        exec_stb = stb; instr = ins; in_set = iset; out_set = oset;
        #1 compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    // Encoding: 111 dir dev xfer clr skip
    function automatic logic [7:0] io(input bit dir, input bit dev, input bit x,
                                      input bit c, input bit s);
        return {3'b111, dir, dev, x, c, s};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("reset", 0, 0, 0, 0);
        step("reset", 0, 0, 0, 0);
        rst_n = 1;
        // R1: all flags clear after reset: skip tests on every device
        for (int k = 0; k < 4; k++) step("R1 after reset", 1, io(k[1], k[0], 0, 0, 1), 0, 0);
        // R2: set input 1 and output 0, then test all
        step("R2 set", 0, 0, 2'b10, 2'b01);
        for (int k = 0; k < 4; k++) step("R2 poll", 1, io(k[1], k[0], 0, 0, 1), 0, 0);
        // R4: strobe low and non-IO opcode with skip bits
        step("R4 no strobe", 0, io(0, 1, 0, 0, 1), 0, 0);
        step("R10 non-io", 1, 8'b110_1_0_111, 0, 0);
        step("R10 poll", 1, io(1, 0, 0, 0, 1), 0, 0);
        // R9 + R5: skip and clear combined on input 1
        step("R9 skip+clr", 1, io(0, 1, 0, 1, 1), 0, 0);
        step("R5 poll", 1, io(0, 1, 0, 0, 1), 0, 0);
        // R6: clear input 0 while device sets it
        step("R6 collide", 1, io(0, 0, 0, 1, 0), 2'b01, 0);
        step("R6 poll", 1, io(0, 0, 0, 0, 1), 0, 0);
        // R7: read from both inputs
        in_data = 16'hA55C;
        step("R7 read0", 1, io(0, 0, 1, 0, 0), 0, 0);
        step("R7 read1", 1, io(0, 1, 1, 0, 0), 0, 0);
        // R8: load output 0 (its flag is set), then poll
        ac_in = 8'h3C;
        step("R8 load0", 1, io(1, 0, 1, 0, 1), 0, 0);
        step("R8 strobe", 0, 0, 0, 0);
        step("R8 poll", 1, io(1, 0, 0, 0, 1), 0, 0);
        ac_in = 8'hC3;
        step("R8 load1", 1, io(1, 1, 1, 0, 0), 0, 2'b10);
        step("R8 poll1", 1, io(1, 1, 0, 0, 1), 0, 0);
        // Random run
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] ri;
            ri = $urandom;
            if ($urandom % 4 != 0) ri[7:5] = 3'b111;
            ac_in = $urandom; in_data = $urandom;
            step("random", ($urandom % 3) != 0, ri, $urandom, $urandom);
        end
        // R1: reset mid-run clears flags
        step("R1 set", 0, 0, 2'b11, 2'b11);
        rst_n = 0;
        step("R1 rst", 0, 0, 0, 0);
        rst_n = 1;
        for (int k = 0; k < 4; k++) step("R1 re-reset", 1, io(k[1], k[0], 0, 0, 1), 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule